// File: doc/BRIEF.md
# Banked ROM Mapper with Split-Port RAM

This block decodes accesses into a 4 KB cartridge window. It maps the upper part of the window onto one of up to seven 4 KB ROM banks. It also fronts a 256-byte RAM that is written through one 256-byte address range and read through a second one.

Bank selection works through hotspot offsets near the top of the window. Any access to a hotspot, whether read or write, switches the bank, unless the bank-lock input is held. The seventh bank exists only when the size input selects the 28 KB configuration.

The RAM write range has a side effect. Reading it acts as a write of whatever the data bus currently carries, and the read returns that same value.

The ROM sits outside the block. The block drives a flat ROM byte address made of the bank number and the offset, and it takes the ROM byte back combinationally. Read data is registered and is valid in the cycle after the access.

Top module: `bank_rom_mapper`

## Requirements
- R1: Reset sets the current bank to 0, clears every RAM byte to 0x00 and sets the read data to 0x00.
- R2: An access (select high with read or write strobe) to offsets 0xFF5, 0xFF6, 0xFF7, 0xFF8, 0xFF9 or 0xFFA loads bank 0, 1, 2, 3, 4 or 5 respectively. The bank output shows the new value after the clock edge that samples the access.
- R3: An access to offset 0xFFB loads bank 6 when sizeSeven is 1. When sizeSeven is 0, the access leaves the bank unchanged.
- R4: While bankLock is 1, hotspot accesses leave the bank unchanged.
- R5: A write to offsets 0x000–0x0FF stores busIn into RAM byte addr[7:0]. The bank lock does not affect this.
- R6: A read of offsets 0x100–0x1FF returns RAM byte addr[7:0] on rdData one cycle after the access.
- R7: A read of offsets 0x000–0x0FF returns busIn. It also stores busIn into RAM byte addr[7:0], unless bankLock is 1, in which case RAM is unchanged.
- R8: A read of any other offset returns the ROM byte at bank × 4096 + offset. romAddr is {curBank, addr}.
- R9: A bank change applies from the next access. A read of a hotspot returns the ROM byte of the bank that was current before the switch.
- R10: bankCount is 7 when sizeSeven is 1 and 6 otherwise.
- R11: A write to offsets 0x100–0x1FF leaves RAM unchanged. Any cycle with select low changes neither the bank nor RAM nor rdData.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| addr | input | 12 | Offset within the cartridge window |
| sel | input | 1 | Window select |
| rdEn | input | 1 | Read strobe |
| wrEn | input | 1 | Write strobe (wins over rdEn) |
| busIn | input | 8 | Data bus value |
| bankLock | input | 1 | Freezes the bank and blocks read-port capture |
| sizeSeven | input | 1 | 1: seven banks (28 KB), 0: six banks |
| romData | input | 8 | ROM byte at romAddr |
| romAddr | output | 15 | Flat ROM byte address |
| rdData | output | 8 | Registered read data |
| curBank | output | 3 | Current bank number |
| bankCount | output | 4 | Number of banks configured |

## Verification
A wrong bank register is visible straight away on romAddr. It also shows on the next ROM read, because each bank returns a distinct byte pattern. Those checks also cover the rule that a hotspot read still returns the old bank's byte.

RAM damage stays hidden until the matching read-port offset is read back. For that reason, every store in the bench, whether intended, blocked by the lock, or a write to the read range, is followed by a read-back of the same byte. Reset clearing is shown the same way, by reading bytes after a reset in the middle of the run.

// File: rtl/bank_mapper_pkg.sv
package bank_mapper_pkg;

  // Source of the byte loaded into the read-data register
  typedef enum logic [1:0] {
    SRC_ROM = 2'd0,
    SRC_RAM = 2'd1,
    SRC_BUS = 2'd2
  } rdSrc_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic   ramStore;
    logic   rdLoad;
    rdSrc_e rdSrc;
  } dpStrobes_t;

endpackage

// File: rtl/bank_mapper_ctrl.sv
module bank_mapper_ctrl
  import bank_mapper_pkg::*;
#(
  parameter int ADDR_W         = 12,
  parameter int RAM_AW         = 8,
  parameter int BANK_W         = 3,
  parameter int NUM_BASE_BANKS = 6,
  parameter int HOT_FIRST      = 'hFF5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              sel,
  input  logic              rdEn,
  input  logic              wrEn,
  input  logic              bankLock,
  input  logic              sizeSeven,
  output logic [BANK_W-1:0] curBank,
  output logic [BANK_W:0]   bankCount,
  output dpStrobes_t        strobes
);

  localparam int NUM_HOT = NUM_BASE_BANKS + 1;
  localparam int REG_W   = ADDR_W - RAM_AW;
  localparam logic [REG_W-1:0] WR_REGION = REG_W'(0);
  localparam logic [REG_W-1:0] RD_REGION = REG_W'(1);

  logic              access;
  logic              isWrite;
  logic              isRead;
  logic              inWrPort;
  logic              inRdPort;
  logic [NUM_HOT-1:0] hotHit;
  logic [BANK_W-1:0] hotBank;
  logic              bankLoad;

  assign access   = sel & (rdEn | wrEn);
  assign isWrite  = sel & wrEn;
  assign isRead   = sel & rdEn & ~wrEn;
  assign inWrPort = (addr[ADDR_W-1:RAM_AW] == WR_REGION);
  assign inRdPort = (addr[ADDR_W-1:RAM_AW] == RD_REGION);

  // One comparator per hotspot; the last one is gated by the size setting
  for (genvar g = 0; g < NUM_HOT; g++) begin : gHot
    if (g < NUM_BASE_BANKS) begin : gBase
      assign hotHit[g] = (addr == ADDR_W'(HOT_FIRST + g));
    end else begin : gExtra
      assign hotHit[g] = (addr == ADDR_W'(HOT_FIRST + g)) & sizeSeven;
    end
  end

  always_comb begin
    hotBank = '0;
    for (int i = 0; i < NUM_HOT; i++) begin
      if (hotHit[i]) hotBank = BANK_W'(i);
    end
  end

  assign bankLoad = access & (|hotHit) & ~bankLock;

  always_ff @(posedge clk) begin
    if (!rstN)         curBank <= '0;
    else if (bankLoad) curBank <= hotBank;
  end

  assign bankCount = sizeSeven ? (BANK_W+1)'(NUM_HOT) : (BANK_W+1)'(NUM_BASE_BANKS);

  always_comb begin
    strobes.ramStore = (isWrite & inWrPort) | (isRead & inWrPort & ~bankLock);
    strobes.rdLoad   = isRead;
    if (inWrPort)      strobes.rdSrc = SRC_BUS;
    else if (inRdPort) strobes.rdSrc = SRC_RAM;
    else               strobes.rdSrc = SRC_ROM;
  end

  // R2
  hot_first_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sel && (rdEn || wrEn) && !bankLock && addr == ADDR_W'(HOT_FIRST)) |=> (curBank == '0));

  // R4
  lock_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sel && (rdEn || wrEn) && bankLock) |=> $stable(curBank));

  // R3
  extra_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sel && (rdEn || wrEn) && !sizeSeven && addr == ADDR_W'(HOT_FIRST + NUM_BASE_BANKS))
      |=> $stable(curBank));

  // R11
  idle_bank_chk: assert property (@(posedge clk) disable iff (!rstN)
    !sel |=> $stable(curBank));

  // R3
  bank_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    curBank <= BANK_W'(NUM_BASE_BANKS));

endmodule

// File: rtl/bank_mapper_datapath.sv
module bank_mapper_datapath
  import bank_mapper_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int RAM_AW = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobes_t        strobes,
  input  logic [RAM_AW-1:0] ramIdx,
  input  logic [DATA_W-1:0] busIn,
  input  logic [DATA_W-1:0] romData,
  output logic [DATA_W-1:0] rdData
);

  localparam int RAM_DEPTH = 1 << RAM_AW;

  logic [DATA_W-1:0] ramMem [RAM_DEPTH];
  logic [DATA_W-1:0] rdNext;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < RAM_DEPTH; i++) ramMem[i] <= '0;
    end else if (strobes.ramStore) begin
      ramMem[ramIdx] <= busIn;
    end
  end

  always_comb begin
    unique case (strobes.rdSrc)
      SRC_BUS: rdNext = busIn;
      SRC_RAM: rdNext = ramMem[ramIdx];
      default: rdNext = romData;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)               rdData <= '0;
    else if (strobes.rdLoad) rdData <= rdNext;
  end

  // R7
  capture_bus_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.rdLoad && strobes.rdSrc == SRC_BUS) |=> (rdData == $past(busIn)));

  // R11
  idle_data_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.rdLoad |=> $stable(rdData));

endmodule

// File: rtl/bank_rom_mapper.sv
module bank_rom_mapper
  import bank_mapper_pkg::*;
#(
  parameter int ADDR_W         = 12,
  parameter int DATA_W         = 8,
  parameter int RAM_AW         = 8,
  parameter int BANK_W         = 3,
  parameter int NUM_BASE_BANKS = 6,
  parameter int HOT_FIRST      = 'hFF5
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [ADDR_W-1:0]        addr,
  input  logic                     sel,
  input  logic                     rdEn,
  input  logic                     wrEn,
  input  logic [DATA_W-1:0]        busIn,
  input  logic                     bankLock,
  input  logic                     sizeSeven,
  input  logic [DATA_W-1:0]        romData,
  output logic [BANK_W+ADDR_W-1:0] romAddr,
  output logic [DATA_W-1:0]        rdData,
  output logic [BANK_W-1:0]        curBank,
  output logic [BANK_W:0]          bankCount
);

  dpStrobes_t strobes;

  bank_mapper_ctrl #(
    .ADDR_W(ADDR_W), .RAM_AW(RAM_AW), .BANK_W(BANK_W),
    .NUM_BASE_BANKS(NUM_BASE_BANKS), .HOT_FIRST(HOT_FIRST)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .addr(addr), .sel(sel), .rdEn(rdEn), .wrEn(wrEn),
    .bankLock(bankLock), .sizeSeven(sizeSeven),
    .curBank(curBank), .bankCount(bankCount), .strobes(strobes)
  );

  bank_mapper_datapath #(
    .DATA_W(DATA_W), .RAM_AW(RAM_AW)
  ) uDp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .ramIdx(addr[RAM_AW-1:0]),
    .busIn(busIn), .romData(romData), .rdData(rdData)
  );

  assign romAddr = {curBank, addr};

endmodule

// File: tb/bank_rom_mapper_test.sv
`timescale 1ns/1ps
module bank_rom_mapper_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:0] addr = '0;
  logic        sel = 1'b0, rdEn = 1'b0, wrEn = 1'b0;
  logic [7:0]  busIn = '0;
  logic        bankLock = 1'b0, sizeSeven = 1'b1;
  logic [7:0]  romData;
  logic [14:0] romAddr;
  logic [7:0]  rdData;
  logic [2:0]  curBank;
  logic [3:0]  bankCount;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  // ROM model: every bank gives a distinct pattern
  function automatic logic [7:0] romByte(input logic [14:0] a);
    return a[7:0] ^ {a[14:12], 5'b0} ^ {4'b0, a[11:8]};
  endfunction
  assign romData = romByte(romAddr);

  bank_rom_mapper uut (
    .clk(clk), .rstN(rstN), .addr(addr), .sel(sel), .rdEn(rdEn), .wrEn(wrEn),
    .busIn(busIn), .bankLock(bankLock), .sizeSeven(sizeSeven), .romData(romData),
    .romAddr(romAddr), .rdData(rdData), .curBank(curBank), .bankCount(bankCount)
  );

  typedef struct packed {
    logic [3:0]  req;
    logic [11:0] a;
    logic        rd;
    logic [7:0]  bus;
    logic        lock;
    logic        seven;
    logic        chkData;
    logic [7:0]  expData;
    logic [2:0]  expBank;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VEC [NV] = '{
    '{4'd5,  12'h010, 1'b0, 8'h5A, 1'b0, 1'b1, 1'b0, 8'h00, 3'd0}, // R5 write
    '{4'd6,  12'h110, 1'b1, 8'h00, 1'b0, 1'b1, 1'b1, 8'h5A, 3'd0}, // R6 read back
    '{4'd8,  12'h234, 1'b1, 8'h00, 1'b0, 1'b1, 1'b1, 8'h36, 3'd0}, // R8 bank 0
    '{4'd2,  12'hFF7, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 8'h00, 3'd2}, // R2 write hotspot
    '{4'd8,  12'h234, 1'b1, 8'h00, 1'b0, 1'b1, 1'b1, 8'h76, 3'd2}, // R8 bank 2
    '{4'd9,  12'hFFA, 1'b1, 8'h00, 1'b0, 1'b1, 1'b1, 8'hB5, 3'd5}, // R9 old bank data
    '{4'd8,  12'h234, 1'b1, 8'h00, 1'b0, 1'b1, 1'b1, 8'h96, 3'd5}, // R8 bank 5
    '{4'd3,  12'hFFB, 1'b1, 8'h00, 1'b0, 1'b1, 1'b1, 8'h54, 3'd6}, // R3 seven banks
    '{4'd8,  12'h500, 1'b1, 8'h00, 1'b0, 1'b1, 1'b1, 8'hC5, 3'd6}, // R8 bank 6
    '{4'd2,  12'hFF5, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 8'h00, 3'd0}, // R2 back to 0
    '{4'd3,  12'hFFB, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 8'h00, 3'd0}, // R3 six banks
    '{4'd7,  12'h020, 1'b1, 8'h3C, 1'b0, 1'b0, 1'b1, 8'h3C, 3'd0}, // R7 capture
    '{4'd7,  12'h120, 1'b1, 8'h00, 1'b0, 1'b0, 1'b1, 8'h3C, 3'd0}, // R7 stored
    '{4'd11, 12'h130, 1'b0, 8'h77, 1'b0, 1'b0, 1'b0, 8'h00, 3'd0}, // R11 write read port
    '{4'd11, 12'h130, 1'b1, 8'h00, 1'b0, 1'b0, 1'b1, 8'h00, 3'd0}, // R11 unchanged
    '{4'd4,  12'hFF8, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 8'h00, 3'd0}, // R4 locked
    '{4'd7,  12'h040, 1'b1, 8'h99, 1'b1, 1'b0, 1'b1, 8'h99, 3'd0}, // R7 locked read
    '{4'd7,  12'h140, 1'b1, 8'h00, 1'b1, 1'b0, 1'b1, 8'h00, 3'd0}, // R7 not stored
    '{4'd2,  12'hFF8, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 8'h00, 3'd3}  // R2 unlocked
  };

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic doAccess(input logic [11:0] a, input logic rd, input logic wr,
                          input logic [7:0] bus, input logic lock, input logic seven);
    @(negedge clk);
    addr = a; sel = 1'b1; rdEn = rd; wrEn = wr; busIn = bus;
    bankLock = lock; sizeSeven = seven;
    @(negedge clk);
    sel = 1'b0; rdEn = 1'b0; wrEn = 1'b0;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual 0x1 expected 0x0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    doReset();
    @(negedge clk);
    check("R1 bank after reset", curBank, 0);
    check("R1 rdData after reset", rdData, 0);
    check("R10 count seven", bankCount, 7);
    doAccess(12'h1FF, 1'b1, 1'b0, 8'h00, 1'b0, 1'b1);
    check("R1 RAM cleared", rdData, 0);

    for (int i = 0; i < NV; i++) begin
      doAccess(VEC[i].a, VEC[i].rd, ~VEC[i].rd, VEC[i].bus, VEC[i].lock, VEC[i].seven);
      if (VEC[i].chkData)
        check($sformatf("R%0d vec %0d data", VEC[i].req, i), rdData, VEC[i].expData);
      check($sformatf("R%0d vec %0d bank", VEC[i].req, i), curBank, VEC[i].expBank);
    end

    // R10 six-bank configuration
    check("R10 count six", bankCount, 6);

    // R8 romAddr composition before the edge
    @(negedge clk);
    addr = 12'hABC; sel = 1'b1; rdEn = 1'b1;
    #1 check("R8 romAddr", romAddr, {3'd3, 12'hABC});
    @(negedge clk);
    sel = 1'b0; rdEn = 1'b0;
    check("R8 rom data bank 3", rdData, 8'hBC ^ 8'h60 ^ 8'h0A);

    // R11 select low: hotspot and RAM write ignored
    @(negedge clk);
    addr = 12'hFF6; wrEn = 1'b1; busIn = 8'hEE;
    @(negedge clk);
    check("R11 idle bank", curBank, 3);
    check("R11 idle rdData", rdData, 8'hBC ^ 8'h60 ^ 8'h0A);
    addr = 12'h010;
    @(negedge clk);
    wrEn = 1'b0;
    doAccess(12'h110, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0);
    check("R11 idle RAM", rdData, 8'h5A);

    // R5 write is not blocked by the lock
    doAccess(12'h0FF, 1'b0, 1'b1, 8'hA5, 1'b1, 1'b0);
    doAccess(12'h1FF, 1'b1, 1'b0, 8'h00, 1'b1, 1'b0);
    check("R5 locked write stored", rdData, 8'hA5);

    // R2 read hotspot path, R9 hotspot data from old bank
    doAccess(12'hFF9, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0);
    check("R9 hotspot read old bank", rdData, 8'hF9 ^ 8'h60 ^ 8'h0F);
    check("R2 read hotspot bank", curBank, 4);

    // R1 reset in mid-run clears bank and RAM
    doReset();
    @(negedge clk);
    check("R1 bank after second reset", curBank, 0);
    doAccess(12'h110, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0);
    check("R1 RAM cleared again", rdData, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule